// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Held Output

This block turns an asynchronous serial line into bytes. It samples the line only on cycles where an external enable pulse is high. That enable runs at a fixed multiple of the bit rate, set by parameter `OVS` (default 8). A frame is one low start bit, `DATA_W` data bits sent least significant bit first, and `STOP_N` high stop bits. The defaults are 8 data bits and 1 stop bit. A falling edge seen on an enable cycle starts a candidate frame. The line is checked again half a bit later; if it is still low, the start is confirmed and each later bit is sampled one full bit period after the previous one.

Each accepted byte goes into a holding register and raises a ready flag. The byte stays there unchanged while the next frame shifts in. The consumer pulses a read acknowledge to release the holding register. Three sticky error flags report problems:

- A byte that arrives while the holding register is still occupied (overrun).
- A frame whose stop sample is low (underrun, a framing error).
- A frame sampled low from start bit through stop bit (line break).

Top module: `serial_rx_held`

## Requirements
- R1: After a synchronous reset, `rx_ready` is 0, `rx_byte` is all zeros and all three error flags are 0.
- R2: A well-formed frame whose stop sample is high delivers its data bits least significant bit first on `rx_byte`. `rx_ready` rises on the clock edge of the enable cycle that samples the last stop bit.
- R3: `rx_byte` holds its value from one accepted byte to the next, including while another frame is being shifted in.
- R4: A one-cycle `rd_ack` pulse while `rx_ready` is 1 clears `rx_ready` on the next edge. An `rd_ack` while `rx_ready` is 0 has no effect.
- R5: A low pulse that has ended before the mid-bit check, which comes `OVS/2` enable cycles after the falling edge is seen, produces no byte and no error.
- R6: A well-formed frame that ends while `rx_ready` is 1 and `rd_ack` is 0 sets `err_overrun`. That byte is discarded, and `rx_byte` and `rx_ready` stay as they were.
- R7: If `rd_ack` is 1 on the same edge that a well-formed frame ends, the new byte is accepted, `rx_ready` stays 1, and no overrun is flagged.
- R8: A frame whose stop sample is low sets `err_underrun`. Its byte is discarded and `rx_ready` is unchanged.
- R9: A frame sampled low at the start, at every data bit and at every stop bit sets `err_break`, together with `err_underrun`.
- R10: All three error flags stay set until the next reset, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, `OVS` pulses per bit period |
| rxd | input | 1 | Serial line, idle high, already synchronous to `clk` |
| rd_ack | input | 1 | Read acknowledge; releases the held byte |
| rx_byte | output | DATA_W | Held received byte |
| rx_ready | output | 1 | A byte is held and has not been acknowledged |
| err_overrun | output | 1 | Sticky: a byte was lost because the holder was full |
| err_underrun | output | 1 | Sticky: a stop sample was low |
| err_break | output | 1 | Sticky: a whole frame was sampled low |

## Verification
The bench starts frames at a known enable phase. This lets it place an acknowledge on the exact edge a frame ends. A design that treats that case as an overrun would raise `err_overrun` and drop the byte; one that lets the acknowledge win last would leave `rx_ready` low. The bench also feeds a frame while a byte is still held and checks the held value partway through. A design that forwards the shift register, or overwrites on overrun, would show a changed `rx_byte` there. Glitches shorter than half a bit, low stop bits and all-low frames are each sent. These show up a receiver that skips the mid-bit check (it would emit a spurious byte), one that loads bytes despite a framing error, or one that fails to flag break.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } rx_phase_e;

    // Outcome of one frame, valid in the cycle its last stop bit is sampled
    typedef struct packed {
        logic done;
        logic stop_ok;
        logic all_low;
    } frame_stat_t;

    // Number of enable pulses from edge detection to the start-bit check
    function automatic int unsigned mid_offset(input int unsigned ovs);
        return (ovs < 2) ? 1 : ovs / 2;
    endfunction

    // Width needed to hold a counter that runs 0 .. n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/srx_sequencer.sv
module srx_sequencer
    import srx_pkg::*;
#(
    parameter int unsigned OVS    = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STOP_N = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    output logic start_ok,
    output logic data_smp,
    output logic stop_smp,
    output logic frame_end
);

    localparam int unsigned CW   = cnt_width(OVS);
    localparam int unsigned BW   = cnt_width(DATA_W);
    localparam int unsigned HALF = mid_offset(OVS);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
    localparam logic [BW-1:0] DATA_LAST = BW'(DATA_W - 1);

    rx_phase_e       phase;
    logic [CW-1:0]   tcnt;
    logic [BW-1:0]   bidx;
    logic            bit_edge;
    logic            half_edge;
    logic            last_stop;

    assign half_edge = (tcnt == HALF_LAST);
    assign bit_edge  = (tcnt == BIT_LAST);

    // Stop-bit counter only exists when more than one stop bit is configured
    generate
        if (STOP_N > 1) begin : g_multi_stop
            localparam int unsigned SW = cnt_width(STOP_N);
            localparam logic [SW-1:0] STOP_LAST = SW'(STOP_N - 1);
            logic [SW-1:0] sidx;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sidx <= '0;
                end else if (tick && phase == PH_STOP && bit_edge) begin
                    sidx <= (sidx == STOP_LAST) ? '0 : sidx + 1'b1;
                end else if (phase != PH_STOP) begin
                    sidx <= '0;
                end
            end
            assign last_stop = (sidx == STOP_LAST);
        end else begin : g_single_stop
            assign last_stop = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
        end else if (tick) begin
            unique case (phase)
                PH_IDLE: begin
                    tcnt <= '0;
                    if (!rxd) phase <= PH_START;
                end
                PH_START: begin
                    if (half_edge) begin
                        tcnt  <= '0;
                        bidx  <= '0;
                        phase <= rxd ? PH_IDLE : PH_DATA;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (bit_edge) begin
                        tcnt <= '0;
                        if (bidx == DATA_LAST) begin
                            phase <= PH_STOP;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                PH_STOP: begin
                    if (bit_edge) begin
                        tcnt <= '0;
                        if (last_stop) phase <= PH_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        start_ok  = tick && (phase == PH_START) && half_edge && !rxd;
        data_smp  = tick && (phase == PH_DATA)  && bit_edge;
        stop_smp  = tick && (phase == PH_STOP)  && bit_edge;
        frame_end = stop_smp && last_stop;
    end

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              start_ok,
    input  logic              data_smp,
    input  logic              stop_smp,
    input  logic              frame_end,
    output logic [DATA_W-1:0] word,
    output frame_stat_t       stat
);

    logic [DATA_W-1:0] shreg;
    logic              zeros_so_far;
    logic              stops_good;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg        <= '0;
            zeros_so_far <= 1'b0;
            stops_good   <= 1'b0;
        end else begin
            if (start_ok) begin
                zeros_so_far <= 1'b1;
                stops_good   <= 1'b1;
            end
            if (data_smp) begin
                shreg        <= {rxd, shreg[DATA_W-1:1]};
                zeros_so_far <= zeros_so_far & ~rxd;
            end
            if (stop_smp) begin
                zeros_so_far <= zeros_so_far & ~rxd;
                stops_good   <= stops_good & rxd;
            end
        end
    end

    // Result includes the stop sample taken in the final cycle
    always_comb begin
        word         = shreg;
        stat.done    = frame_end;
        stat.stop_ok = stops_good & rxd;
        stat.all_low = zeros_so_far & ~rxd;
    end

endmodule

// File: rtl/srx_holder.sv
module srx_holder
    import srx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] word,
    input  frame_stat_t       stat,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] dout,
    output logic              ready,
    output logic              ovr,
    output logic              ufl,
    output logic              brk
);

    logic occupied;
    logic accept;

    // An acknowledge in the same cycle frees the holder for the new byte
    assign occupied = ready & ~rd_ack;
    assign accept   = stat.done & stat.stop_ok & ~occupied;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            ufl   <= 1'b0;
            brk   <= 1'b0;
        end else begin
            if (accept) begin
                dout  <= word;
                ready <= 1'b1;
            end else if (rd_ack) begin
                ready <= 1'b0;
            end
            if (stat.done && stat.stop_ok && occupied) ovr <= 1'b1;
            if (stat.done && !stat.stop_ok) begin
                ufl <= 1'b1;
                if (stat.all_low) brk <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/serial_rx_held.sv
module serial_rx_held
    import srx_pkg::*;
#(
    parameter int unsigned OVS    = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STOP_N = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              err_overrun,
    output logic              err_underrun,
    output logic              err_break
);

    logic              start_ok;
    logic              data_smp;
    logic              stop_smp;
    logic              frame_end;
    logic [DATA_W-1:0] word;
    frame_stat_t       stat;

    srx_sequencer #(
        .OVS    (OVS),
        .DATA_W (DATA_W),
        .STOP_N (STOP_N)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .rxd       (rxd),
        .start_ok  (start_ok),
        .data_smp  (data_smp),
        .stop_smp  (stop_smp),
        .frame_end (frame_end)
    );

    srx_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .rxd       (rxd),
        .start_ok  (start_ok),
        .data_smp  (data_smp),
        .stop_smp  (stop_smp),
        .frame_end (frame_end),
        .word      (word),
        .stat      (stat)
    );

    srx_holder #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .word   (word),
        .stat   (stat),
        .rd_ack (rd_ack),
        .dout   (rx_byte),
        .ready  (rx_ready),
        .ovr    (err_overrun),
        .ufl    (err_underrun),
        .brk    (err_break)
    );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_ack,
    input logic              frame_end,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_ready,
    input logic              err_overrun,
    input logic              err_underrun,
    input logic              err_break
);

    p_ready_from_frame_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(frame_end));

    p_held_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(rx_byte));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rd_ack && !frame_end) |=> !rx_ready);

    p_overrun_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> ($past(rx_ready) && !$past(rd_ack) && $past(frame_end)));

    p_break_with_underrun_r9: assert property (@(posedge clk) disable iff (rst)
        err_break |-> err_underrun);

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_overrun |=> err_overrun);

    p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_underrun |=> err_underrun);

    p_break_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_break |=> err_break);

endmodule

bind serial_rx_held srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_ack       (rd_ack),
    .frame_end    (frame_end),
    .rx_byte      (rx_byte),
    .rx_ready     (rx_ready),
    .err_overrun  (err_overrun),
    .err_underrun (err_underrun),
    .err_break    (err_break)
);

// File: tb/sim_serial_rx_held.sv
module sim_serial_rx_held;

    localparam int OVS    = 8;
    localparam int DW     = 8;
    localparam int SN     = 1;
    localparam int TDIV   = 4;
    localparam int BITCLK = OVS * TDIV;
    localparam int END_TICK = 1 + OVS / 2 + (DW + SN) * OVS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          rxd = 1'b1;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rx_byte;
    logic          rx_ready, err_overrun, err_underrun, err_break;

    int            n_checks = 0;
    int            n_errors = 0;
    bit            auto_ack = 1'b0;
    logic [DW-1:0] expq[$];

    serial_rx_held #(.OVS(OVS), .DATA_W(DW), .STOP_N(SN)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rd_ack(rd_ack),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .err_overrun(err_overrun),
        .err_underrun(err_underrun), .err_break(err_break)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (TDIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [DW-1:0] b, input logic stop_v);
        do @(posedge clk); while (tick !== 1'b1);
        @(negedge clk);
        if (auto_ack && stop_v) expq.push_back(b);
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < DW; i++) begin
            rxd = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stop_v;
        repeat (BITCLK * SN) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor: pops expected bytes as the design presents them
    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack && rx_ready && !rd_ack) begin
                if (expq.size() == 0) begin
                    check("R2/R5 unexpected byte", {24'd0, rx_byte}, 32'hFFFF_FFFF);
                end else begin
                    check("R2 byte", {24'd0, rx_byte}, {24'd0, expq.pop_front()});
                end
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 ready", {31'd0, rx_ready}, 32'd0);
        check("R1 byte", {24'd0, rx_byte}, 32'd0);
        check("R1 flags", {29'd0, err_overrun, err_underrun, err_break}, 32'd0);

        // R2: several patterns through the scoreboard
        auto_ack = 1'b1;
        send_frame(8'hA5, 1'b1);
        send_frame(8'h00, 1'b1);
        send_frame(8'hFF, 1'b1);
        send_frame(8'h3C, 1'b1);
        send_frame(8'h81, 1'b1);
        repeat (10) @(negedge clk);
        check("R2 all bytes seen", expq.size(), 32'd0);

        // R5: glitch shorter than half a bit
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITCLK / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK * 12) @(negedge clk);
        check("R5 no byte", {31'd0, rx_ready}, 32'd0);
        check("R5 no error", {29'd0, err_overrun, err_underrun, err_break}, 32'd0);
        auto_ack = 1'b0;

        // R3/R4/R6 in manual mode
        send_frame(8'h12, 1'b1);
        check("R2 ready set", {31'd0, rx_ready}, 32'd1);
        check("R2 held byte", {24'd0, rx_byte}, 32'h12);
        fork
            send_frame(8'h34, 1'b1);
            begin
                repeat (BITCLK * 5) @(negedge clk);
                check("R3 stable mid-frame", {24'd0, rx_byte}, 32'h12);
            end
        join
        check("R6 overrun set", {31'd0, err_overrun}, 32'd1);
        check("R6 byte kept", {24'd0, rx_byte}, 32'h12);
        check("R6 ready kept", {31'd0, rx_ready}, 32'd1);
        pulse_ack();
        check("R4 ack clears", {31'd0, rx_ready}, 32'd0);
        pulse_ack();
        check("R4 idle ack", {31'd0, rx_ready}, 32'd0);
        check("R4 idle ack byte", {24'd0, rx_byte}, 32'h12);
        check("R10 overrun sticky", {31'd0, err_overrun}, 32'd1);

        // R10 reset clears flags
        do_reset();
        check("R10 cleared", {29'd0, err_overrun, err_underrun, err_break}, 32'd0);

        // R7: acknowledge on the exact completion edge
        send_frame(8'h11, 1'b1);
        fork
            send_frame(8'h22, 1'b1);
            begin
                int cnt;
                cnt = 0;
                wait (rxd === 1'b0);
                while (cnt < END_TICK - 1) begin
                    @(posedge clk);
                    if (tick === 1'b1) cnt++;
                end
                repeat (TDIV) @(negedge clk);
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
            end
        join
        check("R7 new byte", {24'd0, rx_byte}, 32'h22);
        check("R7 ready", {31'd0, rx_ready}, 32'd1);
        check("R7 no overrun", {31'd0, err_overrun}, 32'd0);
        pulse_ack();

        // R8: low stop bit
        send_frame(8'h5A, 1'b0);
        repeat (BITCLK) @(negedge clk);
        check("R8 underrun", {31'd0, err_underrun}, 32'd1);
        check("R8 not ready", {31'd0, rx_ready}, 32'd0);
        check("R8 byte kept", {24'd0, rx_byte}, 32'h22);
        check("R8 no break", {31'd0, err_break}, 32'd0);

        // R9: all-low frame
        send_frame(8'h00, 1'b0);
        repeat (BITCLK) @(negedge clk);
        check("R9 break", {31'd0, err_break}, 32'd1);
        check("R9 underrun", {31'd0, err_underrun}, 32'd1);
        check("R9 not ready", {31'd0, rx_ready}, 32'd0);
        check("R10 no overrun", {31'd0, err_overrun}, 32'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule